// File: doc/BRIEF.md
# SPI Slave Front End with Pause Control

This block sits between the four pins of a serial peripheral slave (select, clock, data in, data out) and the core that decodes commands. All pin inputs are brought into a faster system clock domain through synchronizers. Edges of the serial clock are found on the synchronized copies. Bits are shifted in MSB first on each rising serial clock edge, and every completed byte is handed to the core. Outgoing bits are presented MSB first and change on falling serial clock edges.

An active-low pause input lets the master stop a transfer part-way through without losing its place. The pause is qualified by the serial clock level: it begins or ends only in a cycle where the synchronized serial clock is low. An edge on the pause pin that arrives while the clock is high takes effect when the clock next goes low. While paused, the data output driver is released and both clock and data input are ignored. The bit position and the partial byte are kept. If select is dropped during a pause, the transfer is abandoned and the block locks itself out. It stays locked until the pause pin has been seen high while deselected. A busy flag from the program/erase engine passes through untouched.

Received bytes leave on a valid-only stream (`rx_valid`, `rx_data`) with no ready signal, because a serial master cannot be stalled. A consumer must take each one-cycle beat when it appears. Outgoing bytes use `tx_valid`/`tx_data`/`tx_ready`. `tx_ready` is a one-cycle offer at each byte boundary. If `tx_valid` is low in that cycle, the all-ones fill byte is sent instead, so the source must hold `tx_valid` and `tx_data` steady until it sees the offer.

Top module: `spi_hold_frontend`

## Requirements
- R1: Out of reset, `sdo_oe`, `hold_active`, `rx_valid`, `tx_ready` and `logic_rst` are all 0.
- R2: While selected and not paused, each rising serial clock edge shifts `mosi_pin` into the receive byte, MSB first. After the 8th edge, `rx_valid` pulses for exactly one cycle with the byte on `rx_data`.
- R3: A byte is loaded for transmission when select falls, and again at the first falling clock edge after every 8th rising edge. `tx_ready` is high in the load cycle. The byte is `tx_data` if `tx_valid` is high in that cycle, otherwise 8'hFF. `sdo` shows bit 7 first and moves to the next lower bit on each following falling edge.
- R4: A fall of `hold_n_pin` while the serial clock is low and select is asserted sets `hold_active`. A rise of `hold_n_pin` while the clock is low clears it. Each takes effect within SYNC_STAGES+1 system cycles.
- R5: A fall of `hold_n_pin` while the serial clock is high leaves `hold_active` at 0 until the clock next goes low.
- R6: A rise of `hold_n_pin` while the serial clock is high leaves `hold_active` at 1 until the clock next goes low.
- R7: While `hold_active` is 1, `sdo_oe` is 0 and clock and data input edges are ignored. The bit count and partial byte are kept, so the byte finishes correctly once the pause ends.
- R8: `hold_n_pin` low while select is high (deasserted) never sets `hold_active`.
- R9: A rise of select pulses `logic_rst` for one cycle and discards any partial byte. A later byte is received whole.
- R10: If select rises during a pause, the block ignores all traffic (no `sdo_oe`, no `rx_valid`, no pause) until `hold_n_pin` has been high while select is high. A following select fall starts normally.
- R11: `busy_out` equals `busy_in`, including during a pause.
- R12: `sdo_oe` is 1 exactly while selected, not paused and not locked out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_pin | input | 1 | Active-low select pin |
| sclk_pin | input | 1 | Serial clock pin |
| mosi_pin | input | 1 | Serial data in |
| hold_n_pin | input | 1 | Active-low pause pin |
| busy_in | input | 1 | Busy flag from write/erase engine |
| tx_valid | input | 1 | Outgoing byte available |
| tx_data | input | DATA_W | Outgoing byte |
| tx_ready | output | 1 | One-cycle load offer |
| rx_valid | output | 1 | Received byte strobe |
| rx_data | output | DATA_W | Received byte |
| sdo | output | 1 | Serial data out value |
| sdo_oe | output | 1 | Output enable for sdo driver |
| hold_active | output | 1 | Pause state |
| logic_rst | output | 1 | Reset pulse to core on deselect |
| busy_out | output | 1 | Busy flag passed through |

## Verification
A pin change reaches the synchronized copy after SYNC_STAGES system cycles. State derived from it (`hold_active`, the bit count, `sdo`, `rx_valid`) is registered one cycle later, so every result is due SYNC_STAGES+1 cycles after the stimulus. The bench holds each pin level for six system cycles and samples at the falling system clock edge at the end of that window, when every result has settled. `rx_valid`, `tx_ready` and `logic_rst` last one cycle, so a monitor process counts them and keeps the last received byte for the checks.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;
  localparam int DEF_DATA_W      = 8;
  localparam int DEF_SYNC_STAGES = 2;

  typedef enum logic [1:0] {
    LINK_IDLE   = 2'd0,
    LINK_RUN    = 2'd1,
    LINK_PAUSED = 2'd2,
    LINK_LOCKED = 2'd3
  } link_state_e;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int          STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic q
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= RST_VAL;
          else        chain[g] <= pin;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= RST_VAL;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hold_ctrl.sv
module hold_ctrl
  import spi_hold_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_s,
  input  logic        cs_rise,
  input  logic        sclk_s,
  input  logic        hold_n_s,
  output logic        hold_active,
  output logic        lockout,
  output link_state_e link_state
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lockout <= 1'b0;
    end else if (cs_s && hold_n_s) begin
      lockout <= 1'b0;
    end else if (cs_rise && hold_active) begin
      lockout <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_active <= 1'b0;
    end else if (cs_s || lockout) begin
      hold_active <= 1'b0;
    end else if (!sclk_s) begin
      hold_active <= !hold_n_s;
    end
  end

  always_comb begin
    if (lockout)          link_state = LINK_LOCKED;
    else if (cs_s)        link_state = LINK_IDLE;
    else if (hold_active) link_state = LINK_PAUSED;
    else                  link_state = LINK_RUN;
  end

  // R8
  hold_needs_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_active && !$past(hold_active)) |-> (!$past(cs_s) && !$past(lockout)));

  // R5
  hold_change_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((hold_active != $past(hold_active)) && !$past(cs_s) && !$past(lockout))
      |-> !$past(sclk_s));

  // R10
  locked_no_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lockout) |-> !hold_active);
endmodule

// File: rtl/shift_core.sv
module shift_core #(
  parameter int          DATA_W = 8,
  parameter logic [DATA_W-1:0] FILL = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              start,
  input  logic              rise_en,
  input  logic              fall_en,
  input  logic              frozen,
  input  logic              mosi_s,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_ready,
  output logic              sdo,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [CNT_W-1:0]  bit_cnt;
  logic [DATA_W-1:0] in_sr;
  logic [DATA_W-1:0] out_sr;
  logic [DATA_W-1:0] load_val;
  logic [DATA_W-1:0] in_next;
  logic              boundary_fall;

  assign load_val      = tx_valid ? tx_data : FILL;
  assign in_next       = {in_sr[DATA_W-2:0], mosi_s};
  assign boundary_fall = fall_en && (bit_cnt == '0);
  assign tx_ready      = start || boundary_fall;
  assign sdo           = out_sr[DATA_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt  <= '0;
      in_sr    <= '0;
      out_sr   <= FILL;
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else if (clr) begin
      bit_cnt  <= '0;
      in_sr    <= '0;
      out_sr   <= FILL;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (start) begin
        bit_cnt <= '0;
        in_sr   <= '0;
        out_sr  <= load_val;
      end
      if (rise_en) begin
        in_sr   <= in_next;
        bit_cnt <= (bit_cnt == LAST) ? '0 : bit_cnt + 1'b1;
        if (bit_cnt == LAST) begin
          rx_valid <= 1'b1;
          rx_data  <= in_next;
        end
      end
      if (fall_en) begin
        if (bit_cnt == '0) out_sr <= load_val;
        else               out_sr <= {out_sr[DATA_W-2:0], 1'b1};
      end
    end
  end

  // R7
  frozen_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !clr) |=> ($stable(bit_cnt) && $stable(in_sr) && $stable(out_sr)));

  // R2
  rx_after_last_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> ($past(bit_cnt) == LAST && $past(rise_en)));
endmodule

// File: rtl/spi_hold_frontend.sv
module spi_hold_frontend
  import spi_hold_pkg::*;
#(
  parameter int DATA_W      = DEF_DATA_W,
  parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_pin,
  input  logic              sclk_pin,
  input  logic              mosi_pin,
  input  logic              hold_n_pin,
  input  logic              busy_in,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_ready,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              hold_active,
  output logic              logic_rst,
  output logic              busy_out
);
  logic cs_s, sclk_s, mosi_s, hold_n_s;
  logic cs_d, sclk_d;
  logic cs_rise, cs_fall, sclk_rise, sclk_fall;
  logic lockout, link_run;
  link_state_e link_state;

  pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
    .clk(clk), .rst_n(rst_n), .pin(cs_n_pin), .q(cs_s));
  pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk (
    .clk(clk), .rst_n(rst_n), .pin(sclk_pin), .q(sclk_s));
  pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_mosi (
    .clk(clk), .rst_n(rst_n), .pin(mosi_pin), .q(mosi_s));
  pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_hold (
    .clk(clk), .rst_n(rst_n), .pin(hold_n_pin), .q(hold_n_s));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_d   <= 1'b1;
      sclk_d <= 1'b0;
    end else begin
      cs_d   <= cs_s;
      sclk_d <= sclk_s;
    end
  end

  assign cs_rise   = cs_s && !cs_d;
  assign cs_fall   = !cs_s && cs_d;
  assign sclk_rise = sclk_s && !sclk_d;
  assign sclk_fall = !sclk_s && sclk_d;

  hold_ctrl u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_s       (cs_s),
    .cs_rise    (cs_rise),
    .sclk_s     (sclk_s),
    .hold_n_s   (hold_n_s),
    .hold_active(hold_active),
    .lockout    (lockout),
    .link_state (link_state)
  );

  assign link_run = (link_state == LINK_RUN);

  shift_core #(.DATA_W(DATA_W)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (cs_rise),
    .start   (cs_fall && !lockout),
    .rise_en (sclk_rise && link_run),
    .fall_en (sclk_fall && link_run),
    .frozen  (link_state == LINK_PAUSED),
    .mosi_s  (mosi_s),
    .tx_valid(tx_valid),
    .tx_data (tx_data),
    .tx_ready(tx_ready),
    .sdo     (sdo),
    .rx_valid(rx_valid),
    .rx_data (rx_data)
  );

  assign sdo_oe    = link_run;
  assign logic_rst = cs_rise;
  assign busy_out  = busy_in;

  // R12
  oe_off_when_paused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_active |-> !sdo_oe);

  // R9
  rst_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    logic_rst |=> !logic_rst);
endmodule

// File: tb/spi_hold_frontend_tb.sv
module spi_hold_frontend_tb;
  localparam int HP = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n_pin = 1'b1, sclk_pin = 1'b0, mosi_pin = 1'b0, hold_n_pin = 1'b1;
  logic busy_in = 1'b0, tx_valid = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic tx_ready, rx_valid, sdo, sdo_oe, hold_active, logic_rst, busy_out;
  logic [7:0] rx_data;

  int errors = 0, checks = 0;
  int rx_cnt = 0, rst_cnt = 0, cyc = 0;
  logic [7:0] rx_last = 8'h00;

  always #2 clk = ~clk;

  spi_hold_frontend u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n_pin(cs_n_pin), .sclk_pin(sclk_pin),
    .mosi_pin(mosi_pin), .hold_n_pin(hold_n_pin), .busy_in(busy_in),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .sdo(sdo), .sdo_oe(sdo_oe),
    .hold_active(hold_active), .logic_rst(logic_rst), .busy_out(busy_out));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rx_valid) begin rx_cnt <= rx_cnt + 1; rx_last <= rx_data; end
    if (logic_rst) rst_cnt <= rst_cnt + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle(); repeat (HP) @(negedge clk); endtask

  task automatic clk_bit(input logic b);
    sclk_pin = 1'b0; mosi_pin = b; settle();
    sclk_pin = 1'b1; settle();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic [7:0] seen);
    for (int i = 7; i >= 0; i--) begin
      sclk_pin = 1'b0; mosi_pin = b[i]; settle();
      seen[i] = sdo;
      sclk_pin = 1'b1; settle();
    end
  endtask

  task automatic end_xfer();
    sclk_pin = 1'b0; settle();
    cs_n_pin = 1'b1; settle();
  endtask

  task automatic t_reset();
    chk("R1 sdo_oe", sdo_oe, 0);
    chk("R1 hold_active", hold_active, 0);
    chk("R1 rx_valid", rx_valid, 0);
    chk("R1 tx_ready", tx_ready, 0);
    chk("R1 logic_rst", logic_rst, 0);
  endtask

  task automatic t_basic();
    logic [7:0] seen;
    int n0, r0;
    n0 = rx_cnt; r0 = rst_cnt;
    tx_valid = 1'b1; tx_data = 8'hA5;
    cs_n_pin = 1'b0; settle();
    chk("R12 oe when selected", sdo_oe, 1);
    send_byte(8'h3C, seen);
    chk("R3 first tx byte", seen, 8'hA5);
    chk("R2 rx byte 1", rx_last, 8'h3C);
    tx_data = 8'h5A;
    send_byte(8'hC3, seen);
    chk("R3 second tx byte", seen, 8'h5A);
    chk("R2 rx byte 2", rx_last, 8'hC3);
    chk("R2 rx count", rx_cnt - n0, 2);
    end_xfer();
    chk("R9 rst pulse", rst_cnt - r0, 1);
    chk("R12 oe off deselected", sdo_oe, 0);
  endtask

  task automatic t_fill();
    logic [7:0] seen;
    tx_valid = 1'b0;
    cs_n_pin = 1'b0; settle();
    send_byte(8'h00, seen);
    chk("R3 fill byte", seen, 8'hFF);
    end_xfer();
  endtask

  task automatic t_hold_clk_low();
    logic [7:0] v;
    int n0;
    v = 8'hB6; n0 = rx_cnt;
    cs_n_pin = 1'b0; settle();
    for (int i = 7; i >= 4; i--) clk_bit(v[i]);
    sclk_pin = 1'b0; settle();
    hold_n_pin = 1'b0; settle();
    chk("R4 enter", hold_active, 1);
    chk("R7 oe off", sdo_oe, 0);
    for (int k = 0; k < 3; k++) begin
      busy_in = ~busy_in;
      clk_bit(k[0]);
      chk("R11 busy pass", busy_out, busy_in);
    end
    sclk_pin = 1'b0; settle();
    hold_n_pin = 1'b1; settle();
    chk("R4 exit", hold_active, 0);
    for (int i = 3; i >= 0; i--) clk_bit(v[i]);
    sclk_pin = 1'b0; settle();
    chk("R7 resumed byte", rx_last, 8'hB6);
    chk("R7 one byte only", rx_cnt - n0, 1);
    end_xfer();
  endtask

  task automatic t_hold_clk_high();
    logic [7:0] v;
    v = 8'h6D;
    cs_n_pin = 1'b0; settle();
    clk_bit(v[7]); clk_bit(v[6]);
    hold_n_pin = 1'b0; settle();
    chk("R5 deferred entry", hold_active, 0);
    sclk_pin = 1'b0; settle();
    chk("R5 entry at clk low", hold_active, 1);
    sclk_pin = 1'b1; mosi_pin = ~mosi_pin; settle();
    hold_n_pin = 1'b1; settle();
    chk("R6 deferred exit", hold_active, 1);
    sclk_pin = 1'b0; settle();
    chk("R6 exit at clk low", hold_active, 0);
    for (int i = 5; i >= 0; i--) clk_bit(v[i]);
    sclk_pin = 1'b0; settle();
    chk("R7 byte across high-clk pause", rx_last, 8'h6D);
    end_xfer();
  endtask

  task automatic t_deselected_hold();
    hold_n_pin = 1'b0; settle();
    chk("R8 no hold deselected", hold_active, 0);
    hold_n_pin = 1'b1; settle();
  endtask

  task automatic t_abort();
    logic [7:0] seen;
    cs_n_pin = 1'b0; settle();
    for (int i = 0; i < 4; i++) clk_bit(1'b1);
    end_xfer();
    cs_n_pin = 1'b0; settle();
    send_byte(8'h81, seen);
    chk("R9 partial discarded", rx_last, 8'h81);
    end_xfer();
  endtask

  task automatic t_lockout();
    logic [7:0] seen;
    int n0;
    cs_n_pin = 1'b0; settle();
    for (int i = 0; i < 3; i++) clk_bit(1'b0);
    sclk_pin = 1'b0; settle();
    hold_n_pin = 1'b0; settle();
    chk("R10 paused", hold_active, 1);
    cs_n_pin = 1'b1; settle();
    chk("R10 hold cleared", hold_active, 0);
    n0 = rx_cnt;
    cs_n_pin = 1'b0; settle();
    chk("R10 no hold while locked", hold_active, 0);
    chk("R10 oe off while locked", sdo_oe, 0);
    send_byte(8'h99, seen);
    sclk_pin = 1'b0; settle();
    chk("R10 no rx while locked", rx_cnt - n0, 0);
    hold_n_pin = 1'b1; settle();
    chk("R10 still locked", sdo_oe, 0);
    cs_n_pin = 1'b1; settle();
    cs_n_pin = 1'b0; settle();
    chk("R10 unlocked", sdo_oe, 1);
    send_byte(8'h42, seen);
    sclk_pin = 1'b0; settle();
    chk("R10 rx after unlock", rx_last, 8'h42);
    end_xfer();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1; settle();
    t_reset();
    t_basic();
    t_fill();
    t_hold_clk_low();
    t_hold_clk_high();
    t_deselected_hold();
    t_abort();
    t_lockout();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule